// File: doc/BRIEF.md
# PCI Target Wait-State Controller

This block decides the outcome of each PCI target data phase aimed at one of three internal registers: a receive data register that the host reads, a transmit data register that the host writes, and a host-command register that the host writes. A phase starts with a one-cycle start pulse that carries the direction and the register selector. From the cycle after that pulse, the block does one of three things in each cycle. It asserts target-ready. It holds target-ready negated as a wait state. Or it requests a disconnect with retry.

Each register has its own wait condition. A receive read waits while no data is present. A transmit write waits while the register has no room. A host-command write waits while the previous command is still pending. Waiting happens only in PCI mode with the wait-disable bit cleared. The number of wait states is capped at a parameter (default eight), and once the cap is reached the target requests a retry. When the disable bit is set, a phase that would have waited ends at once with a retry. A completed phase pulses a read or write strobe for one cycle. A retried phase issues no strobe. Target-ready is active high at this block's ports; pad logic inverts it.

Top module: `pci_tgt_wait_ctrl`

## Requirements
- R1: After reset, and after a reset applied in the middle of a phase, trdy, stop_retry, rd_stb and wr_stb are all 0 and no phase is in progress.
- R2: A phase_start pulse in an idle cycle opens a phase whose first decision cycle is the next clock cycle. A phase_start pulse while a phase is open is ignored.
- R3: A read (phase_write=0) of the receive register (phase_sel=2'b00) in PCI mode with waits enabled holds trdy at 0 while rx_has_data is 0. It asserts trdy in the first decision cycle in which rx_has_data is 1.
- R4: A write (phase_write=1) to the transmit register (phase_sel=2'b01) waits while tx_has_room is 0. It completes in the first decision cycle in which tx_has_room is 1.
- R5: A write to the host-command register (phase_sel=2'b10) waits while hcmd_pending is 1. It completes in the first decision cycle in which hcmd_pending is 0.
- R6: After MAX_WAIT wait cycles (default 8) with the condition still unmet, the next decision cycle asserts stop_retry with trdy at 0. If the condition is met in that cycle, trdy is asserted instead.
- R7: With wait_dis=1 in PCI mode, a phase whose condition is unmet asserts stop_retry in its first decision cycle. A phase whose condition is met asserts trdy in that cycle.
- R8: With pci_mode=0, every phase asserts trdy in its first decision cycle, whatever the status flags show.
- R9: In the trdy cycle, rd_stb is 1 for a read and wr_stb is 1 for a write, each for one cycle. In a stop_retry cycle neither strobe is 1.
- R10: A phase that matches none of the three wait cases completes in its first decision cycle. This covers phase_sel=2'b11, a write to the receive register and a read of the transmit register.
- R11: The wait count starts from zero in every phase, so back-to-back phases that retry each receive the full MAX_WAIT wait cycles.
- R12: trdy and stop_retry are never 1 together. Each phase ends with exactly one cycle in which one of them is 1, and the following cycle has both at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pci_mode | input | 1 | 1 = PCI mode, waiting allowed |
| wait_dis | input | 1 | 1 = never insert wait states |
| phase_start | input | 1 | One-cycle pulse opening a data phase |
| phase_write | input | 1 | 1 = write phase, 0 = read phase |
| phase_sel | input | 2 | 00 receive, 01 transmit, 10 host command, 11 other |
| rx_has_data | input | 1 | Receive register holds data |
| tx_has_room | input | 1 | Transmit register can accept data |
| hcmd_pending | input | 1 | Previous host command not yet serviced |
| trdy | output | 1 | Target ready (active high) |
| stop_retry | output | 1 | Disconnect with retry request |
| rd_stb | output | 1 | Read strobe to selected register |
| wr_stb | output | 1 | Write strobe to selected register |

## Verification
A wrong wait counter shows at the ports as a retry that comes one or more cycles early or late against the MAX_WAIT cap, and the bench measures this exactly. A counter that is not cleared shows up on the very next phase, which retries too early. A stuck phase-open state shows as either a terminating cycle repeated on the cycle after termination or a decision cycle that never comes. Both appear within one cycle. A wrong condition decode appears in the first decision cycle of the affected register as a wait, a retry or a strobe where none belongs.

// File: rtl/pci_tw_pkg.sv
package pci_tw_pkg;

    typedef enum logic [1:0] {
        SEL_RXD  = 2'b00,
        SEL_TXD  = 2'b01,
        SEL_HCMD = 2'b10,
        SEL_MISC = 2'b11
    } tw_sel_e;

    typedef struct packed {
        logic    is_write;
        tw_sel_e sel;
    } tw_phase_t;

    typedef enum logic [1:0] {
        DEC_WAIT  = 2'b00,
        DEC_READY = 2'b01,
        DEC_RETRY = 2'b10
    } tw_dec_e;

    typedef struct packed {
        logic rx_has_data;
        logic tx_has_room;
        logic hcmd_pending;
    } tw_flags_t;

    function automatic logic tw_blocked(input tw_phase_t p, input tw_flags_t f);
        logic b;
        b = 1'b0;
        case (p.sel)
            SEL_RXD:  b = !p.is_write && !f.rx_has_data;
            SEL_TXD:  b =  p.is_write && !f.tx_has_room;
            SEL_HCMD: b =  p.is_write &&  f.hcmd_pending;
            default:  b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tw_ready_eval.sv
module tw_ready_eval
    import pci_tw_pkg::*;
(
    input  tw_phase_t phase,
    input  tw_flags_t flags,
    input  logic      pci_mode,
    input  logic      wait_dis,
    input  logic      cap_hit,
    output tw_dec_e   decision
);
    logic blocked;

    always_comb begin
        blocked = tw_blocked(phase, flags);
        if (!pci_mode || !blocked)
            decision = DEC_READY;
        else if (wait_dis || cap_hit)
            decision = DEC_RETRY;
        else
            decision = DEC_WAIT;
    end

endmodule

// File: rtl/tw_wait_counter.sv
module tw_wait_counter #(
    parameter int MAX_WAIT = 8,
    localparam int CNT_W   = $clog2(MAX_WAIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic cap_hit
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_WAIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cap_hit = (cnt_q == CAP);

    // R6: a wait is never granted once the cap is reached
    assert_no_wait_past_cap_R6: assert property (@(posedge clk) disable iff (rst)
        inc |-> !cap_hit);

    // R6: counter stays within the cap
    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CAP);

endmodule

// File: rtl/tw_phase_fsm.sv
module tw_phase_fsm
    import pci_tw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  tw_phase_t phase_in,
    input  tw_dec_e   decision,
    output tw_phase_t phase_q,
    output logic      active,
    output logic      cnt_clear,
    output logic      cnt_inc,
    output logic      trdy,
    output logic      stop_retry,
    output logic      rd_stb,
    output logic      wr_stb
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            phase_q  <= '{is_write: 1'b0, sel: SEL_MISC};
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                phase_q  <= phase_in;
            end
        end else if (decision != DEC_WAIT) begin
            active_q <= 1'b0;
        end
    end

    always_comb begin
        active     = active_q;
        cnt_clear  = !active_q && start;
        cnt_inc    = active_q && (decision == DEC_WAIT);
        trdy       = active_q && (decision == DEC_READY);
        stop_retry = active_q && (decision == DEC_RETRY);
        rd_stb     = trdy && !phase_q.is_write;
        wr_stb     = trdy &&  phase_q.is_write;
    end

    // R12: ready and retry are exclusive
    assert_ready_retry_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(trdy && stop_retry));

    // R12: the terminating cycle is followed by a quiet cycle
    assert_single_end_R12: assert property (@(posedge clk) disable iff (rst)
        (trdy || stop_retry) |=> !(trdy || stop_retry));

    // R9: no strobe on a retry
    assert_no_strobe_on_retry_R9: assert property (@(posedge clk) disable iff (rst)
        stop_retry |-> !(rd_stb || wr_stb));

    // R9: exactly one strobe on completion
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        trdy |-> (rd_stb ^ wr_stb));

endmodule

// File: rtl/pci_tgt_wait_ctrl.sv
module pci_tgt_wait_ctrl
    import pci_tw_pkg::*;
#(
    parameter int MAX_WAIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pci_mode,
    input  logic       wait_dis,
    input  logic       phase_start,
    input  logic       phase_write,
    input  logic [1:0] phase_sel,
    input  logic       rx_has_data,
    input  logic       tx_has_room,
    input  logic       hcmd_pending,
    output logic       trdy,
    output logic       stop_retry,
    output logic       rd_stb,
    output logic       wr_stb
);
    tw_phase_t phase_in;
    tw_phase_t phase_q;
    tw_flags_t flags;
    tw_dec_e   decision;
    logic      active;
    logic      cnt_clear;
    logic      cnt_inc;
    logic      cap_hit;

    assign phase_in = '{is_write: phase_write, sel: tw_sel_e'(phase_sel)};
    assign flags    = '{rx_has_data: rx_has_data,
                        tx_has_room: tx_has_room,
                        hcmd_pending: hcmd_pending};

    tw_ready_eval u_eval (
        .phase    (phase_q),
        .flags    (flags),
        .pci_mode (pci_mode),
        .wait_dis (wait_dis),
        .cap_hit  (cap_hit),
        .decision (decision)
    );

    tw_wait_counter #(.MAX_WAIT(MAX_WAIT)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (cnt_clear),
        .inc     (cnt_inc),
        .cap_hit (cap_hit)
    );

    tw_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (phase_start),
        .phase_in   (phase_in),
        .decision   (decision),
        .phase_q    (phase_q),
        .active     (active),
        .cnt_clear  (cnt_clear),
        .cnt_inc    (cnt_inc),
        .trdy       (trdy),
        .stop_retry (stop_retry),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb)
    );

    // R7: with waits disabled an open phase never idles
    assert_no_wait_when_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        (active && pci_mode && wait_dis) |-> (trdy || stop_retry));

    // R8: outside PCI mode every open phase completes at once
    assert_bypass_outside_pci_R8: assert property (@(posedge clk) disable iff (rst)
        (active && !pci_mode) |-> trdy);

endmodule

// File: tb/pci_tgt_wait_ctrl_bench.sv
`timescale 1ns/1ps
module pci_tgt_wait_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pci_mode = 1'b1;
    logic       wait_dis = 1'b0;
    logic       phase_start = 1'b0;
    logic       phase_write = 1'b0;
    logic [1:0] phase_sel = 2'b00;
    logic       rx_has_data = 1'b1;
    logic       tx_has_room = 1'b1;
    logic       hcmd_pending = 1'b0;
    logic       trdy, stop_retry, rd_stb, wr_stb;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pci_tgt_wait_ctrl u_pci_tgt_wait_ctrl (
        .clk(clk), .rst(rst), .pci_mode(pci_mode), .wait_dis(wait_dis),
        .phase_start(phase_start), .phase_write(phase_write), .phase_sel(phase_sel),
        .rx_has_data(rx_has_data), .tx_has_room(tx_has_room), .hcmd_pending(hcmd_pending),
        .trdy(trdy), .stop_retry(stop_retry), .rd_stb(rd_stb), .wr_stb(wr_stb)
    );

    // vector: pci, dis, write, sel[1:0], release[3:0] (15 = never), exp_waits[3:0], exp_stop
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 2'b00, 4'd0,  4'd0, 1'b0},
        {1'b1, 1'b0, 1'b0, 2'b00, 4'd3,  4'd3, 1'b0},
        {1'b1, 1'b0, 1'b0, 2'b00, 4'd15, 4'd8, 1'b1},
        {1'b1, 1'b0, 1'b1, 2'b01, 4'd5,  4'd5, 1'b0},
        {1'b1, 1'b0, 1'b1, 2'b01, 4'd8,  4'd8, 1'b0},
        {1'b1, 1'b0, 1'b1, 2'b10, 4'd2,  4'd2, 1'b0},
        {1'b1, 1'b0, 1'b1, 2'b10, 4'd15, 4'd8, 1'b1},
        {1'b1, 1'b0, 1'b0, 2'b00, 4'd15, 4'd8, 1'b1},
        {1'b1, 1'b1, 1'b1, 2'b01, 4'd15, 4'd0, 1'b1},
        {1'b1, 1'b1, 1'b0, 2'b00, 4'd0,  4'd0, 1'b0},
        {1'b0, 1'b0, 1'b1, 2'b10, 4'd15, 4'd0, 1'b0},
        {1'b1, 1'b0, 1'b1, 2'b11, 4'd15, 4'd0, 1'b0},
        {1'b1, 1'b0, 1'b0, 2'b01, 4'd15, 4'd0, 1'b0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R3";
            2:       return "R6";
            3:       return "R4";
            4:       return "R6 boundary";
            5:       return "R5";
            6, 7:    return "R11";
            8, 9:    return "R7";
            10:      return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_flags(input bit good);
        rx_has_data  = good;
        tx_has_room  = good;
        hcmd_pending = !good;
    endtask

    task automatic run_phase(input logic p, input logic d, input logic w,
                             input logic [1:0] s, input int rel, input int restart_at,
                             output int waits, output logic got_stop,
                             output logic got_rd, output logic got_wr);
        @(negedge clk);
        pci_mode = p; wait_dis = d; phase_write = w; phase_sel = s;
        set_flags(rel == 0);
        phase_start = 1'b1;
        @(negedge clk);
        phase_start = 1'b0;
        waits = -1; got_stop = 1'b0; got_rd = 1'b0; got_wr = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (k == rel) set_flags(1'b1);
            phase_start = (k == restart_at);
            #1;
            if (trdy || stop_retry) begin
                waits = k; got_stop = stop_retry; got_rd = rd_stb; got_wr = wr_stb;
                break;
            end
            @(negedge clk);
        end
        phase_start = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int   w;
        logic st, rd, wr;
        repeat (3) @(negedge clk);
        #1;
        chk(!trdy && !stop_retry && !rd_stb && !wr_stb, "R1 reset outputs",
            {trdy, stop_retry, rd_stb, wr_stb}, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = VEC[i];
            run_phase(v[13], v[12], v[11], v[10:9], int'(v[8:5]), -1, w, st, rd, wr);
            chk(w == int'(v[4:1]), {vec_tag(i), " wait count"}, w, int'(v[4:1]));
            chk(st == v[0], {vec_tag(i), " retry outcome"}, st, v[0]);
            if (v[0])
                chk(!rd && !wr, "R9 no strobe on retry", {rd, wr}, 0);
            else
                chk(rd == !v[11] && wr == v[11], "R9 strobe direction",
                    {rd, wr}, {!v[11], v[11]});
            @(negedge clk);
            #1;
            chk(!trdy && !stop_retry, "R12 quiet after end", {trdy, stop_retry}, 0);
        end

        // R2: start pulse during an open phase does not restart it
        run_phase(1'b1, 1'b0, 1'b0, 2'b00, 15, 4, w, st, rd, wr);
        chk(w == 8 && st, "R2 restart ignored", w, 8);
        @(negedge clk);
        #1;
        chk(!trdy && !stop_retry, "R2 no phase opened by ignored start",
            {trdy, stop_retry}, 0);

        // R1: reset in the middle of a phase
        @(negedge clk);
        pci_mode = 1'b1; wait_dis = 1'b0; phase_write = 1'b1; phase_sel = 2'b01;
        set_flags(1'b0);
        phase_start = 1'b1;
        @(negedge clk);
        phase_start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!trdy && !stop_retry && !wr_stb, "R1 mid-phase reset",
            {trdy, stop_retry, wr_stb}, 0);
        set_flags(1'b1);
        @(negedge clk);
        #1;
        chk(!trdy && !wr_stb, "R1 phase dropped by reset", {trdy, wr_stb}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule